// File: doc/BRIEF.md
# H-Bridge Current Chopping Controller

This block holds the digital control for one H-bridge that regulates load current by chopping. In the on state it drives one diagonal of the bridge, chosen by the direction input. When the current comparator trips, the block starts a fixed off time. It decays the current through the bridge for that time, then turns the diagonal back on. All timing is counted in ticks of a clock-enable input that stands for the oscillator.

A two-bit decay select chooses how the off time is divided. The first part is fast decay, which drives the opposite diagonal. The rest is slow decay, which turns on both low-side switches. After each off time the comparator is masked for a short or a long blanking window. A change of direction or an edge on the enable input restarts that window. Pulling enable low hands the bridge to external control: the external-mode bit chooses slow decay, which is braking, or fast decay. A zero-current flag turns the whole bridge off during decay so the current cannot reverse. Any fault flag, or the active-low sleep input, turns off all four switches.

Top module: `hbridge_chopper`

## Requirements
- R1: Reset, any bit of `fault` high, or `sleep_n` low drives all four gate outputs to 0 on the next clock edge. Fault or sleep also clears the off-time state and the blanking state, so the diagonal turns on again on the edge after the condition goes away.
- R2: With the block enabled and not in decay, outputs {src_a,src_b,snk_a,snk_b} are 4'b1001 when `phase`=1 and 4'b0110 when `phase`=0.
- R3: A sampled `sense_trip` in the on state, outside blanking, starts a decay that lasts exactly TOFF_TICKS ticks. The diagonal returns on the edge after the last tick.
- R4: The fast part of the off time has F ticks, and the slow part fills the rest. `decay_sel` 00 gives F=0, 01 gives F=round(0.15*TOFF_TICKS), 10 gives F=round(0.48*TOFF_TICKS), and 11 gives F=TOFF_TICKS.
- R5: Slow decay drives 4'b0011 (both sinks). Fast decay drives the diagonal of the opposite phase.
- R6: Blanking of BLANK_SHORT ticks (`blank_long`=0) or BLANK_LONG ticks (`blank_long`=1) starts when the off time ends. While it runs, `sense_trip` is ignored, so a trip held high starts the next decay on the (B+1)-th edge after the edge that ended the off time.
- R7: A change of `phase`, or any edge of `enable`, restarts blanking with the selected length.
- R8: `zero_det` high during internal decay drives all outputs to 0 while the off-time count keeps running.
- R9: With `enable` low, `ext_fast`=0 drives 4'b0011 (braking) regardless of `zero_det`. `ext_fast`=1 drives the opposite diagonal, or 0 while `zero_det` is high.
- R10: src_a and snk_a are never high together, and neither are src_b and snk_b.
- R11: The off-time and blanking counters advance only on cycles with `tick` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oscillator tick enable for all timing |
| phase | input | 1 | Selects the conducting diagonal |
| enable | input | 1 | High: internal chopping; low: external decay |
| ext_fast | input | 1 | Decay used while enable is low: 0 slow, 1 fast |
| decay_sel | input | 2 | Fast-decay share of the off time |
| blank_long | input | 1 | Blanking length select |
| sense_trip | input | 1 | Current comparator tripped |
| zero_det | input | 1 | Load current has reached zero |
| fault | input | NFLT | Fault flags, any high disables the bridge |
| sleep_n | input | 1 | Active-low sleep |
| src_a | output | 1 | High-side enable, leg A |
| src_b | output | 1 | High-side enable, leg B |
| snk_a | output | 1 | Low-side enable, leg A |
| snk_b | output | 1 | Low-side enable, leg B |

## Verification
The bench builds the block with TOFF_TICKS=20, BLANK_SHORT=6 and BLANK_LONG=12. With these values the rounded fast shares become 3 and 10 ticks, and every decay, blanking window and restart completes in tens of cycles. Each off-time split can therefore be checked edge by edge, together with both blanking lengths and the exact cycle on which a held trip is taken again. A long stretch with the tick held low shows that the off time stretches and does not expire.

// File: rtl/hbridge_chopper_pkg.sv
package hbridge_chopper_pkg;

    typedef struct packed {
        logic src_a;
        logic src_b;
        logic snk_a;
        logic snk_b;
    } bridge_t;

    // percentage of a tick count, rounded to nearest
    function automatic int share_ticks(input int total, input int pct);
        return (total * pct + 50) / 100;
    endfunction

    function automatic bridge_t diagonal(input logic ph);
        bridge_t b;
        b.src_a = ph;
        b.snk_b = ph;
        b.src_b = ~ph;
        b.snk_a = ~ph;
        return b;
    endfunction

    localparam bridge_t BRIDGE_OFF   = '0;
    localparam bridge_t BRIDGE_SINKS = '{src_a: 1'b0, src_b: 1'b0, snk_a: 1'b1, snk_b: 1'b1};

endpackage

// File: rtl/hbc_blank_timer.sv
module hbc_blank_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clear,
    input  logic          restart,
    input  logic [CW-1:0] len,
    output logic          active
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } blank_st_t;

    blank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (restart) begin
            st_d.cnt = len;
        end else if (tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);

endmodule

// File: rtl/hbc_offtime.sv
module hbc_offtime #(
    parameter int TOFF_TICKS = 40,
    parameter int CW         = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          clear,
    input  logic          trip_ok,
    input  logic [CW-1:0] fast_len,
    output logic          decay_d,
    output logic          fast_d,
    output logic          decay_q,
    output logic          done
);

    localparam logic [CW-1:0] LAST = CW'(TOFF_TICKS - 1);

    typedef struct packed {
        logic          decay;
        logic [CW-1:0] cnt;
    } off_st_t;

    off_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (clear) begin
            st_d.decay = 1'b0;
            st_d.cnt   = '0;
        end else if (!st_q.decay) begin
            if (trip_ok) begin
                st_d.decay = 1'b1;
                st_d.cnt   = '0;
            end
        end else if (tick) begin
            if (st_q.cnt == LAST) begin
                st_d.decay = 1'b0;
                st_d.cnt   = '0;
                done       = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign decay_d = st_d.decay;
    assign fast_d  = st_d.decay && (st_d.cnt < fast_len);
    assign decay_q = st_q.decay;

endmodule

// File: rtl/hbc_bridge_decode.sv
module hbc_bridge_decode
    import hbridge_chopper_pkg::*;
(
    input  logic    hold,
    input  logic    enable,
    input  logic    phase,
    input  logic    ext_fast,
    input  logic    decay,
    input  logic    fast,
    input  logic    zero_det,
    output bridge_t drv
);

    always_comb begin
        if (hold) begin
            drv = BRIDGE_OFF;
        end else if (!enable) begin
            if (!ext_fast)     drv = BRIDGE_SINKS;
            else if (zero_det) drv = BRIDGE_OFF;
            else               drv = diagonal(~phase);
        end else if (decay) begin
            if (zero_det)      drv = BRIDGE_OFF;
            else if (fast)     drv = diagonal(~phase);
            else               drv = BRIDGE_SINKS;
        end else begin
            drv = diagonal(phase);
        end
    end

endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
    import hbridge_chopper_pkg::*;
#(
    parameter int TOFF_TICKS  = 40,
    parameter int BLANK_SHORT = 6,
    parameter int BLANK_LONG  = 12,
    parameter int NFLT        = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            phase,
    input  logic            enable,
    input  logic            ext_fast,
    input  logic [1:0]      decay_sel,
    input  logic            blank_long,
    input  logic            sense_trip,
    input  logic            zero_det,
    input  logic [NFLT-1:0] fault,
    input  logic            sleep_n,
    output logic            src_a,
    output logic            src_b,
    output logic            snk_a,
    output logic            snk_b
);

    localparam int MAXC = (TOFF_TICKS > BLANK_LONG) ? TOFF_TICKS : BLANK_LONG;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] F_LOW   = CW'(share_ticks(TOFF_TICKS, 15));
    localparam logic [CW-1:0] F_HIGH  = CW'(share_ticks(TOFF_TICKS, 48));
    localparam logic [CW-1:0] F_ALL   = CW'(TOFF_TICKS);
    localparam logic [CW-1:0] B_SHORT = CW'(BLANK_SHORT);
    localparam logic [CW-1:0] B_LONG  = CW'(BLANK_LONG);

    typedef struct packed {
        logic    prev_phase;
        logic    prev_en;
        bridge_t drv;
    } top_st_t;

    top_st_t st_d, st_q;

    logic          hold;
    logic          blank_act;
    logic          trip_ok;
    logic          restart;
    logic          off_done;
    logic          decay_d, fast_d, decay_q;
    logic [CW-1:0] fast_len;
    logic [CW-1:0] blank_len;
    bridge_t       dec_drv;

    assign hold      = (|fault) | ~sleep_n;
    assign trip_ok   = enable & sense_trip & ~blank_act;
    assign blank_len = blank_long ? B_LONG : B_SHORT;
    assign restart   = off_done | (phase != st_q.prev_phase) | (enable != st_q.prev_en);

    always_comb begin
        unique case (decay_sel)
            2'b00:   fast_len = '0;
            2'b01:   fast_len = F_LOW;
            2'b10:   fast_len = F_HIGH;
            default: fast_len = F_ALL;
        endcase
    end

    hbc_offtime #(.TOFF_TICKS(TOFF_TICKS), .CW(CW)) u_off (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clear    (hold | ~enable),
        .trip_ok  (trip_ok),
        .fast_len (fast_len),
        .decay_d  (decay_d),
        .fast_d   (fast_d),
        .decay_q  (decay_q),
        .done     (off_done)
    );

    hbc_blank_timer #(.CW(CW)) u_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clear   (hold),
        .restart (restart),
        .len     (blank_len),
        .active  (blank_act)
    );

    hbc_bridge_decode u_dec (
        .hold     (hold),
        .enable   (enable),
        .phase    (phase),
        .ext_fast (ext_fast),
        .decay    (decay_d),
        .fast     (fast_d),
        .zero_det (zero_det),
        .drv      (dec_drv)
    );

    always_comb begin
        st_d            = st_q;
        st_d.prev_phase = phase;
        st_d.prev_en    = enable;
        st_d.drv        = dec_drv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_a = st_q.drv.src_a;
    assign src_b = st_q.drv.src_b;
    assign snk_a = st_q.drv.snk_a;
    assign snk_b = st_q.drv.snk_b;

endmodule

// File: rtl/hbridge_chopper_chk.sv
module hbridge_chopper_chk #(
    parameter int NFLT = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            enable,
    input logic            ext_fast,
    input logic [NFLT-1:0] fault,
    input logic            sleep_n,
    input logic            src_a,
    input logic            src_b,
    input logic            snk_a,
    input logic            snk_b,
    input logic            blank_act,
    input logic            in_decay
);

    logic hold_c;
    assign hold_c = (|fault) | ~sleep_n;

    // R10: no leg conducts high and low side together
    a_r10_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_a && snk_a) && !(src_b && snk_b));

    // R1: fault or sleep turns the bridge off on the next edge
    a_r1_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        hold_c |=> (!src_a && !src_b && !snk_a && !snk_b));

    // R9: external slow decay brakes on both sinks
    a_r9_brake_sinks: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_c && !enable && !ext_fast) |=> (snk_a && snk_b && !src_a && !src_b));

    // R6: no decay can start while blanking runs
    a_r6_trip_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_c && enable && blank_act && !in_decay) |=> !in_decay);

    // R11: decay cannot end on a cycle without a tick
    a_r11_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_c && enable && in_decay && !tick) |=> in_decay);

endmodule

bind hbridge_chopper hbridge_chopper_chk #(.NFLT(NFLT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .enable    (enable),
    .ext_fast  (ext_fast),
    .fault     (fault),
    .sleep_n   (sleep_n),
    .src_a     (src_a),
    .src_b     (src_b),
    .snk_a     (snk_a),
    .snk_b     (snk_b),
    .blank_act (blank_act),
    .in_decay  (decay_q)
);

// File: tb/hbridge_chopper_tb_top.sv
`timescale 1ns/1ps
module hbridge_chopper_tb_top;

    localparam int T  = 20;
    localparam int BS = 6;
    localparam int BL = 12;
    localparam int NF = 4;
    localparam logic [3:0] ON1   = 4'b1001;
    localparam logic [3:0] ON0   = 4'b0110;
    localparam logic [3:0] SINKS = 4'b0011;
    localparam logic [3:0] OFF   = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1, phase = 1'b0, enable = 1'b0, ext_fast = 1'b0;
    logic [1:0] decay_sel = 2'b00;
    logic blank_long = 1'b0, sense_trip = 1'b0, zero_det = 1'b0, sleep_n = 1'b1;
    logic [NF-1:0] fault = '0;
    logic src_a, src_b, snk_a, snk_b;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic [3:0] val;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    hbridge_chopper #(.TOFF_TICKS(T), .BLANK_SHORT(BS), .BLANK_LONG(BL), .NFLT(NF)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase), .enable(enable),
        .ext_fast(ext_fast), .decay_sel(decay_sel), .blank_long(blank_long),
        .sense_trip(sense_trip), .zero_det(zero_det), .fault(fault), .sleep_n(sleep_n),
        .src_a(src_a), .src_b(src_b), .snk_a(snk_a), .snk_b(snk_b)
    );

    function automatic void check(input logic [3:0] act, input logic [3:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, act, exp);
        end
    endfunction

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // monitor: compare scoreboard items due at this edge
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].at == cyc) begin
            exp_t it;
            it = sb.pop_front();
            check({src_a, src_b, snk_a, snk_b}, it.val, it.tag);
            // R10 leg exclusion seen at the ports
            check({src_a & snk_a, src_b & snk_b, 2'b00}, 4'b0000, "R10");
        end
    end

    task automatic expn(input logic [3:0] v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t it;
            it.at = cyc + 1;
            it.val = v;
            it.tag = tag;
            sb.push_back(it);
            @(negedge clk);
        end
    endtask

    // one internal off time started by a trip; hold_trip keeps the trip high
    task automatic do_decay(input logic [3:0] fv, input logic [3:0] sv, input logic [3:0] onv,
                            input int f, input int b, input bit hold_trip, input string tag);
        sense_trip = 1'b1;
        for (int i = 0; i < T; i++) begin
            expn((i < f) ? fv : sv, 1, tag);
            if (!hold_trip) sense_trip = 1'b0;
        end
        if (hold_trip) begin
            expn(onv, b + 1, "R6");
            expn((f > 0) ? fv : sv, 1, "R6");
            sense_trip = 1'b0;
            fault = 4'b0001;
            expn(OFF, 1, "R1");
            fault = '0;
            expn(onv, 1, "R1");
        end else begin
            expn(onv, b + 2, "R3");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check({src_a, src_b, snk_a, snk_b}, OFF, "R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 on diagonal, phase 1
        enable = 1'b1; phase = 1'b1;
        expn(ON1, 10, "R2");

        // R7 phase change restarts blanking; held trip waits it out
        phase = 1'b0;
        expn(ON0, 1, "R7");
        sense_trip = 1'b1;
        expn(ON0, BS, "R7");
        // R5 slow decay, held trip then R6 short blanking
        decay_sel = 2'b00;
        do_decay(ON1, SINKS, ON0, 0, BS, 1'b1, "R5");

        // R4 15 percent mixed decay (3 of 20)
        decay_sel = 2'b01;
        do_decay(ON1, SINKS, ON0, 3, BS, 1'b0, "R4");

        // R4 48 percent mixed decay (10 of 20) with long blanking (R6)
        blank_long = 1'b1; phase = 1'b1;
        expn(ON1, 14, "R2");
        decay_sel = 2'b10;
        do_decay(ON0, SINKS, ON1, 10, BL, 1'b1, "R4");

        // R8 zero detect in full fast decay
        decay_sel = 2'b11;
        sense_trip = 1'b1;
        expn(ON0, 1, "R5");
        sense_trip = 1'b0; zero_det = 1'b1;
        expn(OFF, 3, "R8");
        zero_det = 1'b0;
        expn(ON0, T - 4, "R8");
        expn(ON1, BL + 2, "R3");

        // R11 off time frozen without ticks
        decay_sel = 2'b00;
        sense_trip = 1'b1;
        expn(SINKS, 1, "R11");
        sense_trip = 1'b0; tick = 1'b0;
        expn(SINKS, 30, "R11");
        tick = 1'b1;
        expn(SINKS, T - 1, "R11");
        expn(ON1, BL + 2, "R11");

        // R9 external decay
        enable = 1'b0; ext_fast = 1'b0;
        expn(SINKS, 2, "R9");
        zero_det = 1'b1;
        expn(SINKS, 2, "R9");
        ext_fast = 1'b1; zero_det = 1'b0;
        expn(ON0, 2, "R9");
        zero_det = 1'b1;
        expn(OFF, 2, "R9");
        zero_det = 1'b0; ext_fast = 1'b0; enable = 1'b1;
        // R7 enable rising restarts blanking
        expn(ON1, 1, "R7");
        sense_trip = 1'b1;
        expn(ON1, BL, "R7");
        expn(SINKS, 1, "R7");
        sense_trip = 1'b0;
        fault = 4'b0100;
        expn(OFF, 1, "R1");
        fault = '0;
        expn(ON1, 1, "R1");

        // R1 every fault bit and sleep
        for (int i = 0; i < NF; i++) begin
            fault = NF'(1) << i;
            expn(OFF, 1, "R1");
            fault = '0;
            expn(ON1, 1, "R1");
        end
        sleep_n = 1'b0;
        expn(OFF, 2, "R1");
        sleep_n = 1'b1;
        expn(ON1, 2, "R1");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL scoreboard has %0d items left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule